// File: doc/BRIEF.md
# Converter Master Serial Result Transmitter

This block sits behind a converter's conversion engine and sends each 18-bit result to a host over a three-wire serial link whose clock it generates itself. A host or system timer pulses the conversion-start input. A timer of configurable length stands in for the analog conversion. When that timer expires, the block strobes a done output and captures the result word. It then shifts the word out MSB first on the serial data line. A frame signal marks the window in which the data is valid.

There are two read modes. In read-after mode, the fresh result is sent as soon as the conversion finishes. BUSY is held high until the last bit has left, so BUSY spans both the conversion and the transfer. In read-during mode, the result of the previous conversion is sent while the next conversion runs. BUSY then covers only the conversion. Separate inputs invert the serial clock and the frame signal and pick the serial clock rate. A select input disables clock generation, for boards where another party owns the serial clock.

Top module: `conv_serial_master`

## Requirements
- R1: After reset, busy_o is 0, sdout_o is 0, sync_o sits at its inactive level (equal to inv_sync_i) and sclk_o sits at its idle level (equal to inv_sclk_i).
- R2: Each transfer carries 18 bits, MSB first. The host samples sdout_o on each rising edge of the logical clock (sclk_o XOR inv_sclk_i). sdout_o changes only on the falling edges of that clock.
- R3: The logical frame (sync_o XOR inv_sync_i) is 1 from the first data bit until the falling clock edge after the 18th bit. sdout_o is 0 whenever the frame is inactive.
- R4: inv_sclk_i=1 inverts sclk_o and inv_sync_i=1 inverts sync_o, with no other change to the transfer.
- R5: In read-after mode (rd_during_i=0), the transfer of the just-finished result starts at the end of the conversion. busy_o stays high for CONV_CYCLES + 36*H cycles, where H is the half period, and falls together with the frame.
- R6: In read-during mode (rd_during_i=1), an accepted start loads the previous result. The frame rises 2*H cycles after the start. busy_o stays high for exactly CONV_CYCLES cycles.
- R7: The half period H equals BASE_HALF * 2^div_sel_i clock cycles, and high and low phases have equal length. div_sel_i is sampled when a transfer is loaded.
- R8: While ext_clk_sel_i=1 at load time, no transfer happens. sclk_o does not toggle and the frame stays inactive, but conversions still run and busy_o lasts CONV_CYCLES cycles.
- R9: cnvst_i is ignored while busy_o is high or a transfer is in progress.
- R10: conv_done_o is a one-cycle pulse in the last cycle of a conversion. result_i is captured in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_sel_i | input | 1 | 1 disables internal serial clock generation |
| rd_during_i | input | 1 | 0 read-after mode, 1 read-during mode |
| inv_sclk_i | input | 1 | Invert serial clock output |
| inv_sync_i | input | 1 | Invert frame output |
| div_sel_i | input | 2 | Serial clock divide exponent |
| cnvst_i | input | 1 | Conversion start request |
| result_i | input | RES_W | Conversion result word |
| conv_done_o | output | 1 | End-of-conversion strobe |
| busy_o | output | 1 | Conversion (and read-after transfer) in progress |
| sclk_o | output | 1 | Generated serial clock |
| sync_o | output | 1 | Data-valid frame |
| sdout_o | output | 1 | Serial data |

## Verification
Several properties are checked on every cycle by the assertions: sdout_o holds still between falling clock edges and stays quiet outside the frame; the bit counter stays in range; conversions start only while busy_o is low; the done strobe lasts one cycle; and, in read-after mode, busy_o falls exactly when the transfer ends. Other behaviour can only be shown by the bench's scenarios. These are the MSB-first word content matched against a scoreboard, the busy lengths in both modes, the start-to-frame delay, the half period for each divide setting, the polarity inversions, the suppression of transfers under external clock select, and the dropping of starts that arrive during a conversion or a transfer.

// File: rtl/conv_ser_pkg.sv
package conv_ser_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_LEAD  = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

  function automatic int unsigned half_len(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction
endpackage

// File: rtl/csm_half_tick.sv
module csm_half_tick #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (tick_o)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half_i));
endmodule

// File: rtl/csm_conv_timer.sv
module csm_conv_timer #(
  parameter int unsigned CONV_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign active_o = active_q;
  assign done_o   = active_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (done_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/csm_shifter.sv
module csm_shifter
  import conv_ser_pkg::*;
#(
  parameter int unsigned RES_W = 18,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             lead_i,
  input  logic [RES_W-1:0] data_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             sclk_o,
  output logic             frame_o,
  output logic             sdout_o,
  output logic             active_o
);
  localparam int unsigned BW = $clog2(RES_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(RES_W - 1);

  tx_state_e        state_q;
  logic [RES_W-1:0] shreg_q;
  logic [BW-1:0]    bit_q;
  logic [CNT_W-1:0] half_q;
  logic             sclk_q;
  logic             lead_q;
  logic             tick;

  csm_half_tick #(.CNT_W(CNT_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q != TX_IDLE),
    .restart_i(load_i && state_q == TX_IDLE),
    .half_i   (half_q),
    .tick_o   (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      half_q  <= CNT_W'(1);
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
    end else if (load_i && state_q == TX_IDLE) begin
      shreg_q <= data_i;
      half_q  <= half_i;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      state_q <= lead_i ? TX_LEAD : TX_SHIFT;
    end else if (tick) begin
      unique case (state_q)
        TX_LEAD: begin
          lead_q <= ~lead_q;
          if (lead_q) state_q <= TX_SHIFT;
        end
        TX_SHIFT: begin
          sclk_q <= ~sclk_q;
          if (sclk_q) begin
            shreg_q <= {shreg_q[RES_W-2:0], 1'b0};
            if (bit_q == LAST_BIT) state_q <= TX_IDLE;
            else                   bit_q   <= bit_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sclk_o   = sclk_q;
  assign frame_o  = (state_q == TX_SHIFT);
  assign sdout_o  = (state_q == TX_SHIFT) ? shreg_q[RES_W-1] : 1'b0;
  assign active_o = (state_q != TX_IDLE);

  assert_data_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_SHIFT && $past(state_q == TX_SHIFT) && !$fell(sclk_q))
      |-> $stable(shreg_q[RES_W-1]));

  assert_bit_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_SHIFT) |-> (bit_q <= LAST_BIT));
endmodule

// File: rtl/conv_serial_master.sv
module conv_serial_master
  import conv_ser_pkg::*;
#(
  parameter int unsigned RES_W       = 18,
  parameter int unsigned CONV_CYCLES = 100,
  parameter int unsigned BASE_HALF   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_sel_i,
  input  logic             rd_during_i,
  input  logic             inv_sclk_i,
  input  logic             inv_sync_i,
  input  logic [1:0]       div_sel_i,
  input  logic             cnvst_i,
  input  logic [RES_W-1:0] result_i,
  output logic             conv_done_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             sync_o,
  output logic             sdout_o
);
  localparam int unsigned MAX_HALF = BASE_HALF * 8;
  localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

  logic             conv_active, conv_done, tx_active;
  logic             start_ok, during_q;
  logic             load_after, load_during;
  logic [RES_W-1:0] last_q;
  logic [CNT_W-1:0] half_w;
  logic             sclk_raw, frame_raw, sdout_raw;

  assign busy_o   = conv_active || (!during_q && tx_active);
  assign start_ok = cnvst_i && !busy_o && !tx_active;
  assign half_w   = CNT_W'(half_len(BASE_HALF, div_sel_i));

  csm_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ok),
    .active_o(conv_active),
    .done_o  (conv_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      during_q <= 1'b0;
      last_q   <= '0;
    end else begin
      if (start_ok)  during_q <= rd_during_i;
      if (conv_done) last_q   <= result_i;
    end
  end

  assign load_after  = conv_done && !during_q && !ext_clk_sel_i;
  assign load_during = start_ok && rd_during_i && !ext_clk_sel_i;

  csm_shifter #(.RES_W(RES_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_after || load_during),
    .lead_i  (load_during),
    .data_i  (load_after ? result_i : last_q),
    .half_i  (half_w),
    .sclk_o  (sclk_raw),
    .frame_o (frame_raw),
    .sdout_o (sdout_raw),
    .active_o(tx_active)
  );

  assign conv_done_o = conv_done;
  assign sclk_o      = sclk_raw ^ inv_sclk_i;
  assign sync_o      = frame_raw ^ inv_sync_i;
  assign sdout_o     = sdout_raw;

  assert_busy_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tx_active) && !during_q) |-> $fell(busy_o));

  assert_quiet_outside_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o == inv_sync_i) |-> !sdout_o);

  assert_start_when_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_active) |-> $past(!busy_o && !tx_active));

  assert_ext_no_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ext_clk_sel_i) && $past(!tx_active)) |-> !$rose(tx_active));
endmodule

// File: tb/conv_serial_master_bench.sv
module conv_serial_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 18;
  localparam int CONV  = 100;
  localparam int BASE  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_sel = 1'b0, rd_during = 1'b0, inv_sclk = 1'b0, inv_sync = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic cnvst = 1'b0;
  logic [RES_W-1:0] result = '0;
  logic conv_done, busy, sclk, sync, sdout;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_serial_master #(.RES_W(RES_W), .CONV_CYCLES(CONV), .BASE_HALF(BASE)) u_conv_serial_master (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_sel_i(ext_sel), .rd_during_i(rd_during),
    .inv_sclk_i(inv_sclk), .inv_sync_i(inv_sync), .div_sel_i(div_sel), .cnvst_i(cnvst),
    .result_i(result), .conv_done_o(conv_done), .busy_o(busy), .sclk_o(sclk),
    .sync_o(sync), .sdout_o(sdout)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [RES_W-1:0] exp_q[$];
  int words_seen = 0, toggles = 0, hi_len = 0, lo_len = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic prev_s = 1'b0;
  logic [RES_W-1:0] word = '0;
  int nbits = 0, hi_cnt = 0, lo_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic s = sclk ^ inv_sclk;
      automatic logic y = sync ^ inv_sync;
      if (s != prev_s) toggles++;
      if (!s && prev_s) begin hi_len = hi_cnt; hi_cnt = 0; end
      if (y) begin
        if (s && !prev_s) begin
          lo_len = lo_cnt; lo_cnt = 0;
          word = {word[RES_W-2:0], sdout};
          nbits++;
          if (nbits == RES_W) begin
            words_seen++;
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected word", int'(word), 0);
            else begin
              automatic logic [RES_W-1:0] e = exp_q.pop_front();
              check(word == e, "R2 word content", int'(word), int'(e));
            end
          end
        end
        if (s) hi_cnt++; else lo_cnt++;
      end else begin
        nbits = 0; lo_cnt = 0;
        if (sdout) begin fails++; checks++; $display("FAIL R3: sdout %0d outside frame expected 0", sdout); end
      end
      prev_s = s;
    end
  end

  task automatic push_exp(input logic [RES_W-1:0] w);
    exp_q.push_back(w);
  endtask

  // pulse start, measure busy length, done position, start-to-frame delay
  task automatic run_conv(output int busy_n, output int done_n, output int done_idx, output int lead_n);
    @(negedge clk) cnvst = 1'b1;
    @(negedge clk) cnvst = 1'b0;
    busy_n = 0; done_n = 0; done_idx = 0; lead_n = 0;
    fork
      begin
        while (busy) begin
          busy_n++;
          if (conv_done) begin done_n++; done_idx = busy_n; end
          @(negedge clk);
        end
      end
      begin
        int k = 0;
        while (!(sync ^ inv_sync) && k < 400) begin k++; @(negedge clk); end
        lead_n = k;
      end
    join
  endtask

  task automatic settle();
    while ((sync ^ inv_sync) || busy) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  int b, dn, di, ld, w0;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(sdout == 0, "R1 sdout", sdout, 0);
    check(sync == inv_sync, "R1 sync idle", sync, inv_sync);
    check(sclk == inv_sclk, "R1 sclk idle", sclk, inv_sclk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 R10 R7: read-after, div 0
    result = 18'h2A5A5; push_exp(18'h2A5A5); w0 = words_seen;
    run_conv(b, dn, di, ld);
    check(b == CONV + 36*BASE, "R5 busy length", b, CONV + 36*BASE);
    check(dn == 1, "R10 done pulse count", dn, 1);
    check(di == CONV, "R10 done position", di, CONV);
    settle();
    check(words_seen == w0 + 1, "R5 word sent", words_seen, w0 + 1);
    check(hi_len == BASE, "R7 high phase div0", hi_len, BASE);
    check(lo_len == BASE, "R7 low phase div0", lo_len, BASE);

    // R7: div 2
    div_sel = 2'd2; result = 18'h1C3F0; push_exp(18'h1C3F0);
    run_conv(b, dn, di, ld);
    check(b == CONV + 36*BASE*4, "R5 busy length div2", b, CONV + 36*BASE*4);
    settle();
    check(hi_len == BASE*4, "R7 high phase div2", hi_len, BASE*4);
    check(lo_len == BASE*4, "R7 low phase div2", lo_len, BASE*4);

    // R9: start during conversion ignored
    div_sel = 2'd0; result = 18'h30F0F; push_exp(18'h30F0F); w0 = words_seen;
    fork
      run_conv(b, dn, di, ld);
      begin repeat (50) @(negedge clk); cnvst = 1'b1; @(negedge clk); cnvst = 1'b0; end
    join
    check(b == CONV + 36*BASE, "R9 busy unaffected", b, CONV + 36*BASE);
    settle();
    check(busy == 0, "R9 no extra conversion", busy, 0);
    check(words_seen == w0 + 1, "R9 one word", words_seen, w0 + 1);

    // R6: read-during sends previous result
    rd_during = 1'b1; result = 18'h0F00F; push_exp(18'h30F0F);
    run_conv(b, dn, di, ld);
    check(b == CONV, "R6 busy length", b, CONV);
    check(ld == 2*BASE, "R6 frame delay", ld, 2*BASE);
    settle();
    // R6 R9: slow clock, transfer outlasts conversion; start during transfer ignored
    div_sel = 2'd3; result = 18'h12345; push_exp(18'h0F00F); w0 = words_seen;
    run_conv(b, dn, di, ld);
    check(b == CONV, "R6 busy length div3", b, CONV);
    check(ld == 2*BASE*8, "R6 frame delay div3", ld, 2*BASE*8);
    repeat (100) @(negedge clk);
    cnvst = 1'b1; @(negedge clk); cnvst = 1'b0;
    @(negedge clk);
    check(busy == 0, "R9 start ignored during transfer", busy, 0);
    settle();
    check(words_seen == w0 + 1, "R6 word sent", words_seen, w0 + 1);
    check(hi_len == BASE*8, "R7 high phase div3", hi_len, BASE*8);

    // R4: inversions, read-after div1
    rd_during = 1'b0; div_sel = 2'd1;
    @(negedge clk) begin inv_sclk = 1'b1; inv_sync = 1'b1; end
    @(posedge clk); @(negedge clk); prev_s = 1'b0;
    check(sclk == 1'b1, "R4 sclk idle inverted", sclk, 1);
    check(sync == 1'b1, "R4 sync idle inverted", sync, 1);
    result = 18'h3FFFE; push_exp(18'h3FFFE); w0 = words_seen;
    @(negedge clk) cnvst = 1'b1;
    @(negedge clk) cnvst = 1'b0;
    repeat (CONV + 5) @(negedge clk);
    check(sync == 1'b0, "R4 sync active low", sync, 0);
    settle();
    check(words_seen == w0 + 1, "R4 word with inversion", words_seen, w0 + 1);
    check(hi_len == BASE*2, "R7 high phase div1", hi_len, BASE*2);
    @(negedge clk) begin inv_sclk = 1'b0; inv_sync = 1'b0; end
    @(posedge clk); @(negedge clk); prev_s = 1'b0;

    // R8: external clock select, no transfer
    ext_sel = 1'b1; result = 18'h2AAAA; w0 = words_seen; toggles = 0;
    run_conv(b, dn, di, ld);
    check(b == CONV, "R8 busy length", b, CONV);
    repeat (200) @(negedge clk);
    check(toggles == 0, "R8 sclk quiet", toggles, 0);
    check(words_seen == w0, "R8 no word", words_seen, w0);
    check(sync == 0, "R8 frame inactive", sync, 0);
    ext_sel = 1'b0;

    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule